// File: doc/BRIEF.md
# I2C Event Flag and Interrupt Register

This block is the control and status register of an I2C interface. A single register address has two faces. A read returns the sampled bus status, four sticky event flags and an attention summary. A write performs clear and command actions. Read and write bits mean different things, so software must never update the register by reading it, changing one bit and writing it back.

The bus logic reports four kinds of event as one-cycle pulses: start seen, stop seen, arbitration lost and data ready. Each pulse sets its own sticky flag. The attention bit is set while any of the four flags is set, and it drives the interrupt request when both the global enable and the peripheral enable are high.

A write can clear flags and can issue one-cycle command strobes to the bus logic: transmit start, transmit stop, idle and clear transmit-active. All ports are plain control and status pins. There is no data stream here, so the block has no valid/ready handshake.

Top module: `i2c_evt_csr`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the read value is 0x81. In that value the received-bit copy is 1, every flag is 0 and the master copy is 0.
- R2: The read value has these bits: bit 7 is the received data bit, bit 6 is attention, bit 5 is data ready, bit 4 is arbitration lost, bit 3 is start seen, bit 2 is stop seen, bit 1 is master, and bit 0 always reads as 1. Bits 7 and 1 show the inputs as sampled at the previous clock edge.
- R3: A write with a 1 in one of the clear bits clears the matching flag at that clock edge. The clear bits are: bit 5 for data ready, bit 4 for arbitration lost, bit 3 for start seen and bit 2 for stop seen.
- R4: A 0 in a clear bit leaves its flag unchanged. The command bits (7, 6, 1 and 0) never change any flag.
- R5: An event pulse sets its flag at the next clock edge. If a clear of the same flag arrives in the same cycle, the event wins and the flag is set.
- R6: Attention (read bit 6) is the OR of the four event flags. It drops only once all four flags are cleared.
- R7: The interrupt request is high exactly when the global enable is 1, the peripheral enable is 1 and attention is set.
- R8: A write with a 1 in one of the command bits makes the matching strobe high for exactly the cycle after the write. The command bits are: bit 7 for clear transmit-active, bit 6 for idle, bit 1 for transmit start and bit 0 for transmit stop. With no write, every strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_start | input | 1 | Start condition seen (one-cycle pulse) |
| evt_stop | input | 1 | Stop condition seen (one-cycle pulse) |
| evt_arb_lost | input | 1 | Arbitration lost (one-cycle pulse) |
| evt_data_rdy | input | 1 | Data ready (one-cycle pulse) |
| rx_bit | input | 1 | Current received data bit |
| is_master | input | 1 | Bus logic is acting as master |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data (clear and command bits) |
| irq_global_en | input | 1 | Global interrupt enable |
| irq_periph_en | input | 1 | I2C interrupt enable |
| rd_data | output | 8 | Register read value |
| cmd_tx_start | output | 1 | Transmit start strobe |
| cmd_tx_stop | output | 1 | Transmit stop strobe |
| cmd_idle | output | 1 | Idle strobe |
| cmd_xact_clr | output | 1 | Clear transmit-active strobe |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that rst_n is low at time zero and that the event and write inputs are stable around each rising clock edge. They place no limit on how often events or writes arrive. Back-to-back writes and an event in the same cycle as a clear are both legal. The stimulus changes every input on the falling edge and holds it through the following rising edge. It also drives the collisions the flag logic must resolve: an event together with a clear of the same flag, an event together with a clear of a different flag, and all four events together with all four clears.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
  localparam int CSR_W      = 8;
  localparam int EVT_N      = 4;  // flag index: 0 stop, 1 start, 2 arb lost, 3 data ready
  localparam int CMD_N      = 4;  // strobe index: 0 tx stop, 1 tx start, 2 idle, 3 clr xact
  // read side bit positions
  localparam int RD_RXBIT   = 7;
  localparam int RD_ATTN    = 6;
  localparam int RD_FLAG_LO = 2;
  localparam int RD_MASTER  = 1;
  localparam int RD_CONST   = 0;
  // write side bit positions
  localparam int WR_XACT    = 7;
  localparam int WR_IDLE    = 6;
  localparam int WR_CLR_LO  = 2;
  localparam int WR_TXSTART = 1;
  localparam int WR_TXSTOP  = 0;
  localparam logic CONST_BIT = 1'b1;
endpackage

// File: rtl/i2c_evt_flag.sv
module i2c_evt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // an event pulse wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);                                          // R5
  AST_CLR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);                             // R3
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(flag_o));                    // R4
endmodule

// File: rtl/i2c_evt_cmd.sv
module i2c_evt_cmd #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] sel_i,
  output logic [N-1:0] strobe_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_o <= '0;
    else        strobe_o <= wr_en ? sel_i : '0;
  end

  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (strobe_o == '0));                               // R8
endmodule

// File: rtl/i2c_evt_csr.sv
module i2c_evt_csr
  import i2c_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_start,
  input  logic             evt_stop,
  input  logic             evt_arb_lost,
  input  logic             evt_data_rdy,
  input  logic             rx_bit,
  input  logic             is_master,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             irq_global_en,
  input  logic             irq_periph_en,
  output logic [CSR_W-1:0] rd_data,
  output logic             cmd_tx_start,
  output logic             cmd_tx_stop,
  output logic             cmd_idle,
  output logic             cmd_xact_clr,
  output logic             irq
);
  logic [EVT_N-1:0] evt_vec;
  logic [EVT_N-1:0] flags;
  logic [CMD_N-1:0] cmd_sel;
  logic [CMD_N-1:0] cmd_q;
  logic             rx_q;
  logic             master_q;
  logic             attn;

  assign evt_vec = {evt_data_rdy, evt_arb_lost, evt_start, evt_stop};

  for (genvar i = 0; i < EVT_N; i++) begin : g_flag
    i2c_evt_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_vec[i]),
      .clr_i  (wr_en & wr_data[WR_CLR_LO+i]),
      .flag_o (flags[i])
    );
  end

  assign cmd_sel = {wr_data[WR_XACT], wr_data[WR_IDLE],
                    wr_data[WR_TXSTART], wr_data[WR_TXSTOP]};

  i2c_evt_cmd #(.N(CMD_N)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .sel_i    (cmd_sel),
    .strobe_o (cmd_q)
  );

  assign {cmd_xact_clr, cmd_idle, cmd_tx_start, cmd_tx_stop} = cmd_q;

  // sampled bus status; the idle bus line reads high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q     <= 1'b1;
      master_q <= 1'b0;
    end else begin
      rx_q     <= rx_bit;
      master_q <= is_master;
    end
  end

  assign attn = |flags;
  assign irq  = irq_global_en & irq_periph_en & attn;

  always_comb begin
    rd_data                             = '0;
    rd_data[RD_RXBIT]                   = rx_q;
    rd_data[RD_ATTN]                    = attn;
    rd_data[RD_FLAG_LO+EVT_N-1:RD_FLAG_LO] = flags;
    rd_data[RD_MASTER]                  = master_q;
    rd_data[RD_CONST]                   = CONST_BIT;
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> !irq);                                    // R7
  AST_START_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[WR_TXSTART]) |=> cmd_tx_start);           // R8
  AST_ATTN_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_vec) |=> rd_data[RD_ATTN]);                           // R6
endmodule

// File: tb/i2c_evt_csr_test.sv
module i2c_evt_csr_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_start = 0, evt_stop = 0, evt_arb_lost = 0, evt_data_rdy = 0;
  logic       rx_bit = 1, is_master = 0, wr_en = 0;
  logic [7:0] wr_data = 8'h00;
  logic       irq_global_en = 0, irq_periph_en = 0;
  logic [7:0] rd_data;
  logic       cmd_tx_start, cmd_tx_stop, cmd_idle, cmd_xact_clr, irq;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #2 clk = ~clk;  // 250 MHz

  i2c_evt_csr uut (
    .clk(clk), .rst_n(rst_n),
    .evt_start(evt_start), .evt_stop(evt_stop),
    .evt_arb_lost(evt_arb_lost), .evt_data_rdy(evt_data_rdy),
    .rx_bit(rx_bit), .is_master(is_master),
    .wr_en(wr_en), .wr_data(wr_data),
    .irq_global_en(irq_global_en), .irq_periph_en(irq_periph_en),
    .rd_data(rd_data), .cmd_tx_start(cmd_tx_start), .cmd_tx_stop(cmd_tx_stop),
    .cmd_idle(cmd_idle), .cmd_xact_clr(cmd_xact_clr), .irq(irq)
  );

  // fields: evt{drdy,arb,start,stop}, wr_en, wr_data, rx, master, gen, pen,
  //         exp rd, exp irq, exp cmd{xact,idle,start,stop}
  localparam int NV = 11;
  localparam logic [29:0] VEC [NV] = '{
    {4'b0001, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'hC5, 1'b1, 4'h0},
    {4'b0010, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h4F, 1'b0, 4'h0},
    {4'b0000, 1'b1, 8'h0C, 1'b0, 1'b1, 1'b1, 1'b1, 8'h03, 1'b0, 4'h0},
    {4'b1000, 1'b1, 8'h20, 1'b1, 1'b0, 1'b1, 1'b1, 8'hE1, 1'b1, 4'h0},
    {4'b0000, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'hE1, 1'b0, 4'h0},
    {4'b0000, 1'b1, 8'h43, 1'b1, 1'b0, 1'b1, 1'b1, 8'hE1, 1'b1, 4'h7},
    {4'b0100, 1'b1, 8'h20, 1'b1, 1'b0, 1'b1, 1'b1, 8'hD1, 1'b1, 4'h0},
    {4'b0000, 1'b1, 8'h80, 1'b1, 1'b0, 1'b1, 1'b1, 8'hD1, 1'b1, 4'h8},
    {4'b0000, 1'b1, 8'h10, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81, 1'b0, 4'h0},
    {4'b1111, 1'b1, 8'h3C, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFD, 1'b1, 4'h0},
    {4'b0000, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, 8'h81, 1'b0, 4'hF}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] ev, input logic we, input logic [7:0] wd,
                       input logic rx, input logic m, input logic ge, input logic pe);
    {evt_data_rdy, evt_arb_lost, evt_start, evt_stop} = ev;
    wr_en = we; wr_data = wd; rx_bit = rx; is_master = m;
    irq_global_en = ge; irq_periph_en = pe;
    @(posedge clk);
    @(negedge clk);
    evt_data_rdy = 0; evt_arb_lost = 0; evt_start = 0; evt_stop = 0; wr_en = 0;
  endtask

  function automatic logic [7:0] cmds();
    return {4'h0, cmd_xact_clr, cmd_idle, cmd_tx_start, cmd_tx_stop};
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset read", rd_data, 8'h81);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    chk("R1 reset strobes", cmds(), 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [29:0] v;
      v = VEC[i];
      drive(v[29:26], v[25], v[24:17], v[16], v[15], v[14], v[13]);
      chk($sformatf("R2 R3 R4 R5 R6 vec %0d read", i), rd_data, v[12:5]);
      chk($sformatf("R7 vec %0d irq", i), {7'd0, irq}, {7'd0, v[4]});
      chk($sformatf("R8 vec %0d strobes", i), cmds(), {4'h0, v[3:0]});
    end

    // R8: strobe lasts exactly one cycle
    drive(4'b0000, 1'b1, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 tx start strobe", cmds(), 8'h02);
    drive(4'b0000, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R8 strobe gone without write", cmds(), 8'h00);

    // R7: both enables required
    drive(4'b0010, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R7 periph enable low", {7'd0, irq}, 8'h00);
    chk("R6 start flag read", rd_data, 8'hC9);
    drive(4'b0000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R7 global enable low", {7'd0, irq}, 8'h00);
    drive(4'b0000, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R7 both enables", {7'd0, irq}, 8'h01);

    // R3 R5: clear start with a stop event in the same cycle
    drive(4'b0001, 1'b1, 8'h08, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R3 R5 clear start, stop event", rd_data, 8'hC5);

    // R1: reset in the middle of a run
    rx_bit = 0; is_master = 1; rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 mid-run reset read", rd_data, 8'h81);
    chk("R1 mid-run reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    rx_bit = 1; is_master = 0;
    drive(4'b0000, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2 status sampled", rd_data, 8'h03);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule